// File: doc/BRIEF.md
# MCTP over SMBus transmit packet framer

This block turns an outbound MCTP message into a series of SMBus block-write frames. It hands them to an I2C controller front end as a stream of commands: one start command carrying the address byte, a data command per frame byte, and a stop command at the end of each frame. For every fragment the block builds the SMBus header and the MCTP transport header itself. It then streams the fragment's payload bytes from a byte source, appends the packet error code and ends the transfer.

A pulse on `start_i` latches the peer context: peer address, peer endpoint ID, own address, own endpoint ID, message tag and initial packet sequence. The block then asks a fragment supplier for fragments one at a time. Each fragment states its payload length and its start-of-message and end-of-message marks. A fragment of length zero means the message is finished. The block then issues a single bus-release command and goes idle. An error or NACK reported by the controller abandons the frame at once. Bus arbitration and the bit-level I2C engine sit outside this block.

Top module: `mctp_smbus_tx_framer`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o` and `frag_req_o` are all low.
- R2: After `start_i`, the block holds `frag_req_o` high until `frag_valid_i` is seen. If the accepted fragment has length 0, the only command issued is RELEASE (kind code 3), after which `busy_o` falls.
- R3: Each frame opens with a START command (kind code 0) whose data is the peer 7-bit address shifted left by one with bit 0 clear. DATA commands (kind code 1) follow. The first DATA byte is 0x0F. The second is the fragment length plus 5. The third is the own 7-bit address shifted left by one with bit 0 set.
- R4: DATA bytes four to seven are 0x01, the peer endpoint ID, the own endpoint ID, and a flags byte. The flags byte carries start-of-message in bit 7, end-of-message in bit 6, the sequence in bits 5:4, 0 in bit 3, and the tag in bits 2:0.
- R5: The fragment's payload bytes follow the header as DATA commands, in source order. Each byte is taken from `pld_data_i` and consumed by one `pld_rd_o` cycle, exactly as many bytes as the fragment length.
- R6: After the payload comes one DATA byte holding the CRC-8 (polynomial 0x07, initial value 0, most significant bit first). It covers the START address byte and every DATA byte before it. A STOP command (kind code 2) follows, and then a new fragment request.
- R7: The sequence of the first packet equals `seq_init_i` as captured at `start_i`. Each later packet of the same message adds one, modulo 4.
- R8: A command whose `cmd_ready_i` is low stays valid, with the same kind and data, until it is accepted.
- R9: When `ctl_err_i` is high while the block is busy, on the next cycle `busy_o` and `cmd_valid_o` are low. No further command, including RELEASE, is issued for that message.
- R10: A fragment may carry up to 250 payload bytes. At that size the byte count field is 255.
- R11: Peer address, peer endpoint ID, own address, own endpoint ID and tag are captured at `start_i`. Changing those inputs during the message does not change the frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin sending a message; captures the context inputs |
| own_addr_i | input | 7 | Own 7-bit bus address |
| peer_addr_i | input | 7 | Destination 7-bit bus address |
| own_eid_i | input | 8 | Own endpoint ID |
| peer_eid_i | input | 8 | Destination endpoint ID |
| tag_i | input | 3 | Message tag |
| seq_init_i | input | 2 | Sequence of the first packet |
| frag_req_o | output | 1 | Waiting for the next fragment descriptor |
| frag_valid_i | input | 1 | Fragment descriptor present |
| frag_len_i | input | 8 | Payload length of the fragment (0 ends the message) |
| frag_som_i | input | 1 | Fragment starts the message |
| frag_eom_i | input | 1 | Fragment ends the message |
| pld_rd_o | output | 1 | Current payload byte consumed this cycle |
| pld_data_i | input | 8 | Current payload byte |
| cmd_valid_o | output | 1 | Command to the controller front end valid |
| cmd_kind_o | output | 2 | 0 START, 1 DATA, 2 STOP, 3 RELEASE |
| cmd_data_o | output | 8 | Address byte for START, frame byte for DATA |
| cmd_ready_i | input | 1 | Controller accepts the command this cycle |
| ctl_err_i | input | 1 | Controller reports NACK or error |
| busy_o | output | 1 | A message is in progress |

## Verification
The bench sends a message that is only the zero-length terminator, which shows that the release path never opens a frame. A one-fragment message checks every header field and the CRC against a bitwise model. A three-fragment message with the sequence starting at 3 shows the sequence wrapping to 0. Changing the context inputs in the middle of that message separates captured values from live ones. The same frames are then sent with the controller stalling two cycles in three, which exposes any command that moves before it is accepted. A 250-byte fragment tests the byte count limit. An error raised in the middle of the payload shows that the block stops without issuing a release.

// File: rtl/mctp_txf_pkg.sv
package mctp_txf_pkg;

   // command kinds towards the controller front end
   typedef enum logic [1:0] {
      CMD_START   = 2'd0,
      CMD_DATA    = 2'd1,
      CMD_STOP    = 2'd2,
      CMD_RELEASE = 2'd3
   } cmd_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADDR,
      ST_HDR,
      ST_PLD,
      ST_PEC,
      ST_STOP,
      ST_REL
   } fr_state_e;

   // one byte of a non-reflected CRC-8 with initial value folded in by the caller
   function automatic logic [7:0] pec_step(input logic [7:0] crc,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
      logic [7:0] c;
      c = crc ^ din;
      for (int b = 0; b < 8; b++) begin
         c = c[7] ? ((c << 1) ^ poly) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/mctp_txf_pec.sv
module mctp_txf_pec
   import mctp_txf_pkg::*;
#(
   parameter logic [7:0] POLY      = 8'h07,
   parameter bit         USE_TABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       restart,
   input  logic [7:0] din,
   output logic [7:0] pec_o
);

   logic [7:0] crc_q;
   logic [7:0] base;
   logic [7:0] crc_nxt;

   assign base = restart ? 8'h00 : crc_q;

   generate
      if (USE_TABLE) begin : g_table
         // byte-wide lookup: crc' = T[crc ^ din]
         logic [7:0] tbl [256];
         for (genvar g = 0; g < 256; g++) begin : g_ent
            assign tbl[g] = pec_step(8'h00, 8'(g), POLY);
         end
         assign crc_nxt = tbl[base ^ din];
      end else begin : g_logic
         assign crc_nxt = pec_step(base, din, POLY);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= 8'h00;
      end else if (en) begin
         crc_q <= crc_nxt;
      end
   end

   assign pec_o = crc_q;

   // R6: a restarted accumulation depends only on the first byte
   p_pec_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && restart) |=> (crc_q == pec_step(8'h00, $past(din), POLY)));

endmodule

// File: rtl/mctp_txf_hdr.sv
module mctp_txf_hdr #(
   parameter int         ADDR_W    = 7,
   parameter int         EID_W     = 8,
   parameter int         TAG_W     = 3,
   parameter int         SEQ_W     = 2,
   parameter int         LEN_W     = 8,
   parameter int         IDX_W     = 3,
   parameter int         CNT_EXTRA = 5,
   parameter logic [7:0] CMD_CODE  = 8'h0F,
   parameter logic [7:0] VERSION   = 8'h01
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [EID_W-1:0]  peer_eid,
   input  logic [EID_W-1:0]  own_eid,
   input  logic              som,
   input  logic              eom,
   input  logic [SEQ_W-1:0]  seq,
   input  logic [TAG_W-1:0]  tag,
   output logic [7:0]        byte_o
);

   localparam int PAD_W = 8 - 2 - SEQ_W - TAG_W;

   logic [7:0] flags;
   logic [7:0] count;
   logic [7:0] src_byte;

   // R4: flags layout {som, eom, seq, pad, tag}
   assign flags    = {som, eom, seq, {PAD_W{1'b0}}, tag};
   // R3: byte count covers source byte, transport header and payload
   assign count    = 8'(len + LEN_W'(CNT_EXTRA));
   assign src_byte = {own_addr, 1'b1};

   always_comb begin
      unique case (idx)
         IDX_W'(1): byte_o = CMD_CODE;
         IDX_W'(2): byte_o = count;
         IDX_W'(3): byte_o = src_byte;
         IDX_W'(4): byte_o = VERSION;
         IDX_W'(5): byte_o = peer_eid;
         IDX_W'(6): byte_o = own_eid;
         IDX_W'(7): byte_o = flags;
         default:   byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/mctp_txf_seq.sv
module mctp_txf_seq #(
   parameter int SEQ_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEQ_W-1:0] init,
   input  logic             inc,
   output logic [SEQ_W-1:0] seq_o
);

   logic [SEQ_W-1:0] seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= '0;
      end else if (load) begin
         seq_q <= init;
      end else if (inc) begin
         seq_q <= seq_q + 1'b1;
      end
   end

   assign seq_o = seq_q;

   // R7: one step per sent packet, wrapping
   p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1)));

   p_seq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && inc));

endmodule

// File: rtl/mctp_smbus_tx_framer.sv
module mctp_smbus_tx_framer
   import mctp_txf_pkg::*;
#(
   parameter int         ADDR_W        = 7,
   parameter int         EID_W         = 8,
   parameter int         TAG_W         = 3,
   parameter int         SEQ_W         = 2,
   parameter int         LEN_W         = 8,
   parameter int         MAX_PLD       = 250,
   parameter logic [7:0] CMD_CODE      = 8'h0F,
   parameter logic [7:0] VERSION       = 8'h01,
   parameter logic [7:0] PEC_POLY      = 8'h07,
   parameter bit         PEC_USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic [ADDR_W-1:0] peer_addr_i,
   input  logic [EID_W-1:0]  own_eid_i,
   input  logic [EID_W-1:0]  peer_eid_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic [SEQ_W-1:0]  seq_init_i,
   output logic              frag_req_o,
   input  logic              frag_valid_i,
   input  logic [LEN_W-1:0]  frag_len_i,
   input  logic              frag_som_i,
   input  logic              frag_eom_i,
   output logic              pld_rd_o,
   input  logic [7:0]        pld_data_i,
   output logic              cmd_valid_o,
   output logic [1:0]        cmd_kind_o,
   output logic [7:0]        cmd_data_o,
   input  logic              cmd_ready_i,
   input  logic              ctl_err_i,
   output logic              busy_o
);

   localparam int               IDX_W     = 3;
   localparam int               CNT_EXTRA = 4 + 1;  // transport header + source byte
   localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(7);
   localparam logic [LEN_W-1:0] MAX_LEN   = LEN_W'(MAX_PLD);

   initial begin
      p_cfg_fields_r4: assert (ADDR_W + 1 == 8 && EID_W == 8 && TAG_W + SEQ_W + 3 == 8)
         else $error("field widths do not fill the header bytes");
      p_cfg_limit_r10: assert (MAX_PLD + CNT_EXTRA <= 255 && MAX_PLD < (1 << LEN_W))
         else $error("payload limit exceeds the byte count field");
   end

   fr_state_e          state_q;
   logic [ADDR_W-1:0]  peer_addr_q, own_addr_q;
   logic [EID_W-1:0]   peer_eid_q, own_eid_q;
   logic [TAG_W-1:0]   tag_q;
   logic [LEN_W-1:0]   len_q, rem_q;
   logic               som_q, eom_q;
   logic [IDX_W-1:0]   idx_q;
   logic [SEQ_W-1:0]   seq;
   logic [7:0]         hdr_byte;
   logic [7:0]         pec;
   cmd_kind_e          kind;
   logic               fire;

   // ------------------------------------------------------------------ output side
   always_comb begin
      cmd_valid_o = 1'b1;
      kind        = CMD_DATA;
      cmd_data_o  = 8'h00;
      unique case (state_q)
         ST_ADDR: begin kind = CMD_START;   cmd_data_o = {peer_addr_q, 1'b0}; end
         ST_HDR:  begin kind = CMD_DATA;    cmd_data_o = hdr_byte;            end
         ST_PLD:  begin kind = CMD_DATA;    cmd_data_o = pld_data_i;          end
         ST_PEC:  begin kind = CMD_DATA;    cmd_data_o = pec;                 end
         ST_STOP: begin kind = CMD_STOP;                                      end
         ST_REL:  begin kind = CMD_RELEASE;                                   end
         default: begin cmd_valid_o = 1'b0;                                   end
      endcase
   end

   assign cmd_kind_o = kind;
   assign fire       = cmd_valid_o && cmd_ready_i && !ctl_err_i;
   assign pld_rd_o   = (state_q == ST_PLD) && fire;
   assign frag_req_o = (state_q == ST_REQ);
   assign busy_o     = (state_q != ST_IDLE);

   // ------------------------------------------------------------------ control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         peer_addr_q <= '0;
         own_addr_q  <= '0;
         peer_eid_q  <= '0;
         own_eid_q   <= '0;
         tag_q       <= '0;
         len_q       <= '0;
         rem_q       <= '0;
         som_q       <= 1'b0;
         eom_q       <= 1'b0;
         idx_q       <= '0;
      end else if (ctl_err_i && state_q != ST_IDLE) begin
         state_q <= ST_IDLE;  // R9: abandon frame and message
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               peer_addr_q <= peer_addr_i;  // R11: context captured once
               own_addr_q  <= own_addr_i;
               peer_eid_q  <= peer_eid_i;
               own_eid_q   <= own_eid_i;
               tag_q       <= tag_i;
               state_q     <= ST_REQ;
            end
            ST_REQ: if (frag_valid_i) begin
               if (frag_len_i == '0) begin
                  state_q <= ST_REL;        // R2
               end else begin
                  len_q   <= frag_len_i;
                  som_q   <= frag_som_i;
                  eom_q   <= frag_eom_i;
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: if (fire) begin
               idx_q   <= IDX_W'(1);
               state_q <= ST_HDR;
            end
            ST_HDR: if (fire) begin
               if (idx_q == HDR_LAST) begin
                  rem_q   <= len_q;
                  state_q <= ST_PLD;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_PLD: if (fire) begin
               rem_q <= rem_q - 1'b1;
               if (rem_q == LEN_W'(1)) state_q <= ST_PEC;
            end
            ST_PEC:  if (fire) state_q <= ST_STOP;
            ST_STOP: if (fire) state_q <= ST_REQ;
            ST_REL:  if (fire) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ------------------------------------------------------------------ datapath blocks
   mctp_txf_hdr #(
      .ADDR_W(ADDR_W), .EID_W(EID_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W),
      .LEN_W(LEN_W), .IDX_W(IDX_W), .CNT_EXTRA(CNT_EXTRA),
      .CMD_CODE(CMD_CODE), .VERSION(VERSION)
   ) u_hdr (
      .idx(idx_q), .len(len_q), .own_addr(own_addr_q),
      .peer_eid(peer_eid_q), .own_eid(own_eid_q),
      .som(som_q), .eom(eom_q), .seq(seq), .tag(tag_q),
      .byte_o(hdr_byte)
   );

   mctp_txf_seq #(.SEQ_W(SEQ_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .load((state_q == ST_IDLE) && start_i && !ctl_err_i),
      .init(seq_init_i),
      .inc((state_q == ST_STOP) && fire),
      .seq_o(seq)
   );

   mctp_txf_pec #(.POLY(PEC_POLY), .USE_TABLE(PEC_USE_TABLE)) u_pec (
      .clk(clk), .rst_n(rst_n),
      .en(fire && (state_q == ST_ADDR || state_q == ST_HDR || state_q == ST_PLD)),
      .restart(state_q == ST_ADDR),
      .din(cmd_data_o),
      .pec_o(pec)
   );

   // ------------------------------------------------------------------ assertions
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!cmd_valid_o && !frag_req_o));

   p_zero_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frag_req_o && frag_valid_i && frag_len_i == '0 && !ctl_err_i)
      |=> (cmd_valid_o && cmd_kind_o == CMD_RELEASE));

   p_stop_then_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_kind_o == CMD_STOP) |=> frag_req_o);

   p_hold_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i && !ctl_err_i)
      |=> (cmd_valid_o && $stable(cmd_kind_o) && $stable(cmd_data_o)));

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_err_i && busy_o) |=> (!busy_o && !cmd_valid_o));

   p_len_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frag_req_o && frag_valid_i) |-> (frag_len_i <= MAX_LEN));

   p_pop_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pld_rd_o |-> (cmd_kind_o == CMD_DATA && busy_o));

endmodule

// File: tb/mctp_smbus_tx_framer_test.sv
module mctp_smbus_tx_framer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [6:0] own_addr_i = 7'h51;
   logic [6:0] peer_addr_i = 7'h2A;
   logic [7:0] own_eid_i = 8'h09;
   logic [7:0] peer_eid_i = 8'h1D;
   logic [2:0] tag_i = 3'd5;
   logic [1:0] seq_init_i = 2'd0;
   logic       frag_req_o;
   logic       frag_valid_i = 1'b0;
   logic [7:0] frag_len_i = 8'd0;
   logic       frag_som_i = 1'b0;
   logic       frag_eom_i = 1'b0;
   logic       pld_rd_o;
   logic [7:0] pld_data_i;
   logic       cmd_valid_o;
   logic [1:0] cmd_kind_o;
   logic [7:0] cmd_data_o;
   logic       cmd_ready_i = 1'b1;
   logic       ctl_err_i = 1'b0;
   logic       busy_o;

   always #10 clk = ~clk;  // 50 MHz

   mctp_smbus_tx_framer uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .own_addr_i(own_addr_i), .peer_addr_i(peer_addr_i),
      .own_eid_i(own_eid_i), .peer_eid_i(peer_eid_i),
      .tag_i(tag_i), .seq_init_i(seq_init_i),
      .frag_req_o(frag_req_o), .frag_valid_i(frag_valid_i),
      .frag_len_i(frag_len_i), .frag_som_i(frag_som_i), .frag_eom_i(frag_eom_i),
      .pld_rd_o(pld_rd_o), .pld_data_i(pld_data_i),
      .cmd_valid_o(cmd_valid_o), .cmd_kind_o(cmd_kind_o), .cmd_data_o(cmd_data_o),
      .cmd_ready_i(cmd_ready_i), .ctl_err_i(ctl_err_i), .busy_o(busy_o)
   );

   localparam logic [1:0] K_START = 2'd0, K_DATA = 2'd1, K_STOP = 2'd2, K_REL = 2'd3;

   int checks = 0;
   int fails  = 0;

   // stimulus state
   logic [7:0] pd [0:511];
   int         pptr = 0;
   bit         pend_pop = 0;
   int         fl [0:7];
   bit         fs [0:7];
   bit         fe [0:7];
   int         nfrag = 0;
   int         fi = 0;
   bit         presented = 0;
   bit         rdy_mode = 0;
   int         cyc = 0;
   bit         err_arm = 0;
   int         err_at = 0;
   bit         err_was = 0;
   logic       post_valid = 1'b1;
   logic       post_busy = 1'b1;

   // observed and expected command logs
   logic [1:0] lg_k [0:1023];
   logic [7:0] lg_b [0:1023];
   int         lg_n = 0;
   logic [1:0] ex_k [0:1023];
   logic [7:0] ex_b [0:1023];
   string      ex_r [0:1023];
   int         ex_n = 0;

   assign pld_data_i = pd[pptr];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // controller and sources, driven away from the rising edge
   always @(negedge clk) begin
      if (pend_pop) begin pptr++; pend_pop = 0; end
      if (presented) begin fi++; presented = 0; end
      if (frag_req_o && fi < nfrag) begin
         frag_valid_i = 1'b1;
         frag_len_i   = 8'(fl[fi]);
         frag_som_i   = fs[fi];
         frag_eom_i   = fe[fi];
         presented    = 1;
      end else begin
         frag_valid_i = 1'b0;
      end
      cyc++;
      cmd_ready_i = rdy_mode ? ((cyc % 3) == 0) : 1'b1;
      err_was   = ctl_err_i;
      ctl_err_i = err_arm && cmd_valid_o && (lg_n == err_at);
      if (ctl_err_i) err_arm = 0;
      #1;
      if (err_was) begin
         post_valid = cmd_valid_o;
         post_busy  = busy_o;
      end
      if (cmd_valid_o && cmd_ready_i && !ctl_err_i) begin
         lg_k[lg_n] = cmd_kind_o;
         lg_b[lg_n] = cmd_data_o;
         lg_n++;
         if (pld_rd_o) pend_pop = 1;
      end
   end

   function automatic logic [7:0] crc_bits(input logic [7:0] c, input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         logic fb;
         fb = c[7] ^ b[i];
         c  = {c[6:0], 1'b0};
         if (fb) c = c ^ 8'h07;
      end
      return c;
   endfunction

   task automatic add_ex(input logic [1:0] k, input logic [7:0] b, input string r);
      ex_k[ex_n] = k; ex_b[ex_n] = b; ex_r[ex_n] = r; ex_n++;
   endtask

   // expected frame, built from the requirements
   task automatic ex_frame(input int len, input bit som, input bit eom, input int seq,
                           input int p0, input logic [6:0] pa, input logic [7:0] pe,
                           input logic [6:0] oa, input logic [7:0] oe, input logic [2:0] tg,
                           input string ctx_r, input string seq_r);
      logic [7:0] crc;
      logic [7:0] hb [0:6];
      hb[0] = 8'h0F; hb[1] = 8'(len + 5); hb[2] = {oa, 1'b1}; hb[3] = 8'h01;
      hb[4] = pe; hb[5] = oe; hb[6] = {som, eom, 2'(seq), 1'b0, tg};
      add_ex(K_START, {pa, 1'b0}, ctx_r);
      crc = crc_bits(8'h00, {pa, 1'b0});
      for (int i = 0; i < 7; i++) begin
         string r;
         r = (i == 1 && len == 250) ? "R10" : (i == 6) ? seq_r : (i < 3) ? "R3" : ctx_r;
         add_ex(K_DATA, hb[i], r);
         crc = crc_bits(crc, hb[i]);
      end
      for (int i = 0; i < len; i++) begin
         add_ex(K_DATA, pd[p0 + i], "R5");
         crc = crc_bits(crc, pd[p0 + i]);
      end
      add_ex(K_DATA, crc, "R6");
      add_ex(K_STOP, 8'h00, "R6");
   endtask

   task automatic compare(input string req);
      chk(lg_n == ex_n, req, "command count", lg_n, ex_n);
      for (int i = 0; i < ex_n && i < lg_n; i++) begin
         chk(lg_k[i] == ex_k[i], ex_r[i], $sformatf("kind of command %0d", i), lg_k[i], ex_k[i]);
         if (ex_k[i] != K_STOP && ex_k[i] != K_REL)
            chk(lg_b[i] == ex_b[i], ex_r[i], $sformatf("byte of command %0d", i), lg_b[i], ex_b[i]);
      end
   endtask

   task automatic fill_pd(input int seed);
      for (int i = 0; i < 512; i++) pd[i] = 8'((i * 37 + seed) ^ (i >> 3));
   endtask

   task automatic run_msg(input bit alter);
      int n;
      lg_n = 0; pptr = 0; fi = 0; presented = 0; pend_pop = 0; ex_n = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (alter) begin
         peer_eid_i = 8'hEE; peer_addr_i = 7'h11; own_eid_i = 8'h77;
         own_addr_i = 7'h22; tag_i = 3'd1;
      end
      n = 0;
      while (busy_o && n < 5000) begin @(negedge clk); n++; end
      repeat (2) @(negedge clk);
   endtask

   task automatic restore_ctx();
      own_addr_i = 7'h51; peer_addr_i = 7'h2A; own_eid_i = 8'h09;
      peer_eid_i = 8'h1D; tag_i = 3'd5;
   endtask

   task automatic t_reset();
      #2;
      chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
      chk(cmd_valid_o == 1'b0, "R1", "command valid after reset", cmd_valid_o, 0);
      chk(frag_req_o == 1'b0, "R1", "fragment request after reset", frag_req_o, 0);
   endtask

   task automatic t_zero_only();
      nfrag = 1; fl[0] = 0; fs[0] = 1; fe[0] = 1;
      run_msg(0);
      add_ex(K_REL, 8'h00, "R2");
      compare("R2");
      chk(busy_o == 1'b0, "R2", "busy after release", busy_o, 0);
   endtask

   task automatic t_single();
      fill_pd(11); seq_init_i = 2'd2;
      nfrag = 2; fl[0] = 3; fs[0] = 1; fe[0] = 1; fl[1] = 0;
      run_msg(0);
      ex_frame(3, 1, 1, 2, 0, 7'h2A, 8'h1D, 7'h51, 8'h09, 3'd5, "R4", "R4");
      add_ex(K_REL, 8'h00, "R2");
      compare("R3");
   endtask

   task automatic t_multi();
      fill_pd(90); seq_init_i = 2'd3;
      nfrag = 4;
      fl[0] = 5; fs[0] = 1; fe[0] = 0;
      fl[1] = 4; fs[1] = 0; fe[1] = 0;
      fl[2] = 2; fs[2] = 0; fe[2] = 1;
      fl[3] = 0;
      run_msg(1);
      // R11: frames use the context as captured at start
      ex_frame(5, 1, 0, 3, 0, 7'h2A, 8'h1D, 7'h51, 8'h09, 3'd5, "R11", "R7");
      ex_frame(4, 0, 0, 0, 5, 7'h2A, 8'h1D, 7'h51, 8'h09, 3'd5, "R11", "R7");
      ex_frame(2, 0, 1, 1, 9, 7'h2A, 8'h1D, 7'h51, 8'h09, 3'd5, "R11", "R7");
      add_ex(K_REL, 8'h00, "R2");
      compare("R7");
      restore_ctx();
   endtask

   task automatic t_backpressure();
      fill_pd(201); seq_init_i = 2'd1; rdy_mode = 1;
      nfrag = 3; fl[0] = 6; fs[0] = 1; fe[0] = 0; fl[1] = 1; fs[1] = 0; fe[1] = 1; fl[2] = 0;
      run_msg(0);
      ex_frame(6, 1, 0, 1, 0, 7'h2A, 8'h1D, 7'h51, 8'h09, 3'd5, "R8", "R8");
      ex_frame(1, 0, 1, 2, 6, 7'h2A, 8'h1D, 7'h51, 8'h09, 3'd5, "R8", "R8");
      add_ex(K_REL, 8'h00, "R8");
      compare("R8");
      rdy_mode = 0;
   endtask

   task automatic t_max();
      fill_pd(55); seq_init_i = 2'd0;
      nfrag = 2; fl[0] = 250; fs[0] = 1; fe[0] = 1; fl[1] = 0;
      run_msg(0);
      ex_frame(250, 1, 1, 0, 0, 7'h2A, 8'h1D, 7'h51, 8'h09, 3'd5, "R10", "R4");
      add_ex(K_REL, 8'h00, "R10");
      compare("R10");
   endtask

   task automatic t_abort();
      int seen;
      fill_pd(3); seq_init_i = 2'd0;
      nfrag = 2; fl[0] = 8; fs[0] = 1; fe[0] = 1; fl[1] = 0;
      err_at = 10; err_arm = 1; post_valid = 1'b1; post_busy = 1'b1;
      run_msg(0);
      chk(post_valid == 1'b0, "R9", "command valid the cycle after error", post_valid, 0);
      chk(post_busy == 1'b0, "R9", "busy the cycle after error", post_busy, 0);
      seen = lg_n;
      repeat (20) @(negedge clk);
      #2;
      chk(lg_n == 10, "R9", "commands accepted before abort", lg_n, 10);
      chk(lg_n == seen, "R9", "no command after abort", lg_n, seen);
      chk(frag_req_o == 1'b0, "R9", "fragment request after abort", frag_req_o, 0);
      chk(cmd_valid_o == 1'b0, "R9", "command valid long after abort", cmd_valid_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_zero_only();
      t_single();
      t_multi();
      t_backpressure();
      t_max();
      t_abort();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule